// File: doc/BRIEF.md
# Path-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters. It picks an entry by XOR-ing a history register with low bits of the branch's fetch address. Fetch presents an address with a valid strobe and gets back, in the same cycle, a taken/not-taken guess, the table index used and a snapshot of the history. Fetch must carry the index and the snapshot with the branch until the branch resolves.

The history register advances speculatively on every lookup, using the guessed direction. A parameter picks what it records. Outcome mode shifts in one direction bit per branch. Path mode shifts in several bits per branch: a fold of the branch address, with the direction mixed into the lowest bit. In path mode, identical outcome sequences reached through different branches land on different counters. A later stage sends back each resolved branch with its index, its real direction and a mispredict flag. Every report trains the addressed counter. A mispredict report also rebuilds the history from the returned snapshot.

Top module: `hist_dir_pred`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken), so every lookup predicts not-taken, and the history snapshot `lk_ckpt` reads zero.
- R2: Each cycle with `up_valid` high moves the counter at `up_index` up by one when `up_taken` is 1 and down by one when it is 0. The counter saturates at 3 and at 0. This happens whatever the value of `up_mispred`.
- R3: `lk_taken` is bit 1 of the counter selected in the same cycle, so counter values 2 and 3 predict taken. It responds combinationally to `lk_addr`.
- R4: `lk_index` equals `lk_ckpt` XOR `lk_addr[IDX_W+1:2]`. `lk_ckpt` is the history as it stands before the current lookup changes it.
- R5: In outcome mode, a cycle with `lk_valid` high (and no mispredict report) shifts the history left by one bit at the next edge. The predicted direction enters bit 0.
- R6: In path mode, a lookup shifts the history left by PATH_BITS bits. The bits that enter are `(lk_addr[5:2] ^ lk_addr[9:6])[PATH_BITS-1:0]`, with bit 0 also XOR-ed with the predicted direction.
- R7: A cycle with `up_valid` and `up_mispred` both high replaces the history at the next edge. The new value is `up_ckpt` advanced once by the R5/R6 rule, using `up_taken` as the direction and `up_addr` as the address. This overrides a lookup in the same cycle.
- R8: Without a lookup and without a mispredict report, the history holds its value. An update with `up_mispred` low leaves the history alone.
- R9: When a lookup and an update address the same counter in one cycle, the lookup returns the counter's value from before the update. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A branch is being looked up this cycle |
| lk_addr | input | ADDR_W | Fetch address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_index | output | IDX_W | Counter index used for this lookup |
| lk_ckpt | output | IDX_W | History before this lookup, to be returned on a mispredict |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_index | input | IDX_W | Counter index that the branch was predicted with |
| up_taken | input | 1 | Resolved direction of the branch |
| up_mispred | input | 1 | The branch was mispredicted |
| up_ckpt | input | IDX_W | History snapshot taken at the branch's lookup |
| up_addr | input | ADDR_W | Fetch address of the resolved branch |

## Verification
A lookup and a training update can fall in the same cycle on the same counter. The bench provokes this by choosing the lookup address as the current history XOR the update index. It judges the result by checking that the prediction still reflects the old counter value, and that a lookup of the same entry one cycle later reflects the new one. A lookup and a mispredict report can also coincide. In that case the bench drives both at once and checks that the next snapshot comes from the returned checkpoint, not from the speculative shift. Both cases run on an outcome-mode and a path-mode instance side by side, against a model built from the requirements.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

   typedef enum logic {
      HM_OUTCOME = 1'b0,
      HM_PATH    = 1'b1
   } hist_mode_e;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_RESET = 2'd1;

   // saturating two-bit step toward the resolved direction
   function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
      ctr_t n;
      if (taken) n = (c == 2'd3) ? c : c + 2'd1;
      else       n = (c == 2'd0) ? c : c - 2'd1;
      return n;
   endfunction

   // history bits consumed per branch
   function automatic int shift_of(input hist_mode_e m, input int path_bits);
      return (m == HM_PATH) ? path_bits : 1;
   endfunction

endpackage

// File: rtl/hdp_ctr_table.sv
module hdp_ctr_table
   import hdp_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic                        rd_taken,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic                        wr_taken,
   output logic [2*(1<<IDX_W)-1:0]     ctr_flat
);

   localparam int DEPTH = 1 << IDX_W;

   ctr_t ctr_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_RESET;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_next(ctr_q[wr_idx], wr_taken);
      end
   end

   // read returns the registered value: a same-cycle write is not forwarded
   assign rd_taken = ctr_q[rd_idx][1];

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign ctr_flat[2*g +: 2] = ctr_q[g];
   end

endmodule

// File: rtl/hdp_hist.sv
module hdp_hist
   import hdp_pkg::*;
#(
   parameter int         HIST_W    = 6,
   parameter int         ADDR_W    = 32,
   parameter hist_mode_e MODE      = HM_PATH,
   parameter int         PATH_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spec_en,
   input  logic              spec_taken,
   input  logic [ADDR_W-1:0] spec_addr,
   input  logic              fix_en,
   input  logic              fix_taken,
   input  logic [ADDR_W-1:0] fix_addr,
   input  logic [HIST_W-1:0] fix_ckpt,
   output logic [HIST_W-1:0] hist_q
);

   localparam int SHIFT = shift_of(MODE, PATH_BITS);

   logic [SHIFT-1:0]  spec_bits;
   logic [SHIFT-1:0]  fix_bits;
   logic [HIST_W-1:0] hist_d;

   if (MODE == HM_PATH) begin : g_path
      function automatic logic [SHIFT-1:0] path_bits(input logic [ADDR_W-1:0] a,
                                                     input logic t);
         logic [3:0] fold;
         fold = a[5:2] ^ a[9:6];
         return fold[SHIFT-1:0] ^ SHIFT'(t);
      endfunction
      logic unused_path;
      assign unused_path = ^{spec_addr[ADDR_W-1:10], spec_addr[1:0],
                             fix_addr[ADDR_W-1:10], fix_addr[1:0]};
      assign spec_bits = path_bits(spec_addr, spec_taken);
      assign fix_bits  = path_bits(fix_addr, fix_taken);
   end else begin : g_outcome
      logic unused_addr;
      assign unused_addr = ^{spec_addr, fix_addr};
      assign spec_bits = spec_taken;
      assign fix_bits  = fix_taken;
   end

   // a mispredict repair outranks a speculative advance in the same cycle
   always_comb begin
      if (fix_en)       hist_d = {fix_ckpt[HIST_W-1-SHIFT:0], fix_bits};
      else if (spec_en) hist_d = {hist_q[HIST_W-1-SHIFT:0], spec_bits};
      else              hist_d = hist_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= hist_d;
   end

endmodule

// File: rtl/hist_dir_pred.sv
module hist_dir_pred
   import hdp_pkg::*;
#(
   parameter int         IDX_W     = 6,
   parameter int         ADDR_W    = 32,
   parameter hist_mode_e MODE      = HM_PATH,
   parameter int         PATH_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_taken,
   output logic [IDX_W-1:0]  lk_index,
   output logic [IDX_W-1:0]  lk_ckpt,
   input  logic              up_valid,
   input  logic [IDX_W-1:0]  up_index,
   input  logic              up_taken,
   input  logic              up_mispred,
   input  logic [IDX_W-1:0]  up_ckpt,
   input  logic [ADDR_W-1:0] up_addr
);

   localparam int SHIFT = shift_of(MODE, PATH_BITS);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 2 || IDX_W > 12) begin : g_bad_idx
      $error("hist_dir_pred: IDX_W must lie in 2..12");
   end
   if (ADDR_W < 10 || ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("hist_dir_pred: ADDR_W too narrow for index and fold bits");
   end
   if (PATH_BITS < 1 || PATH_BITS > 4) begin : g_bad_path
      $error("hist_dir_pred: PATH_BITS must lie in 1..4");
   end
   if (SHIFT >= IDX_W) begin : g_bad_shift
      $error("hist_dir_pred: shift per branch must be below IDX_W");
   end

   logic [IDX_W-1:0]       hist_q;
   logic [2*DEPTH-1:0]     ctr_flat;
   logic                   fix_en;
   logic                   unused_lk;

   assign fix_en    = up_valid & up_mispred;
   assign lk_ckpt   = hist_q;
   assign lk_index  = hist_q ^ lk_addr[IDX_W+1:2];
   assign unused_lk = ^{lk_addr[ADDR_W-1:IDX_W+2], lk_addr[1:0]};

   hdp_hist #(
      .HIST_W    (IDX_W),
      .ADDR_W    (ADDR_W),
      .MODE      (MODE),
      .PATH_BITS (PATH_BITS)
   ) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .spec_en    (lk_valid),
      .spec_taken (lk_taken),
      .spec_addr  (lk_addr),
      .fix_en     (fix_en),
      .fix_taken  (up_taken),
      .fix_addr   (up_addr),
      .fix_ckpt   (up_ckpt),
      .hist_q     (hist_q)
   );

   hdp_ctr_table #(
      .IDX_W (IDX_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_index),
      .rd_taken (lk_taken),
      .wr_en    (up_valid),
      .wr_idx   (up_index),
      .wr_taken (up_taken),
      .ctr_flat (ctr_flat)
   );

endmodule

// File: rtl/hdp_chk.sv
module hdp_chk #(
   parameter int IDX_W = 6,
   parameter int SHIFT = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    lk_valid,
   input logic [IDX_W-1:0]        lk_ckpt,
   input logic                    up_valid,
   input logic [IDX_W-1:0]        up_index,
   input logic                    up_taken,
   input logic                    up_mispred,
   input logic [IDX_W-1:0]        up_ckpt,
   input logic [2*(1<<IDX_W)-1:0] ctr_flat
);

   a_r2_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && ctr_flat[{up_index, 1'b0} +: 2] == 2'd3)
      |=> ctr_flat[{$past(up_index), 1'b0} +: 2] == 2'd3);

   a_r2_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && ctr_flat[{up_index, 1'b0} +: 2] == 2'd0)
      |=> ctr_flat[{$past(up_index), 1'b0} +: 2] == 2'd0);

   a_r5_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !(up_valid && up_mispred))
      |=> lk_ckpt[IDX_W-1:SHIFT] == $past(lk_ckpt[IDX_W-1-SHIFT:0]));

   a_r7_repair: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_mispred)
      |=> lk_ckpt[IDX_W-1:SHIFT] == $past(up_ckpt[IDX_W-1-SHIFT:0]));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_valid && !(up_valid && up_mispred))
      |=> $stable(lk_ckpt));

endmodule

bind hist_dir_pred hdp_chk #(
   .IDX_W (IDX_W),
   .SHIFT (SHIFT)
) u_hdp_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_ckpt    (lk_ckpt),
   .up_valid   (up_valid),
   .up_index   (up_index),
   .up_taken   (up_taken),
   .up_mispred (up_mispred),
   .up_ckpt    (up_ckpt),
   .ctr_flat   (ctr_flat)
);

// File: tb/test_hist_dir_pred.sv
module test_hist_dir_pred;

   localparam int CLK_P = 10;
   localparam int IW    = 6;
   localparam int AW    = 32;
   localparam int PB    = 2;
   localparam int DEPTH = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          up_valid = 1'b0;
   logic [IW-1:0] up_index = '0;
   logic          up_taken = 1'b0;
   logic          up_mispred = 1'b0;
   logic [IW-1:0] up_ckpt = '0;
   logic [AW-1:0] up_addr = '0;

   logic          p_taken, g_taken;
   logic [IW-1:0] p_index, g_index, p_ckpt, g_ckpt;

   int total = 0;
   int bad   = 0;

   logic [IW-1:0] mh_p, mh_g;
   logic [1:0]    mc [DEPTH];

   always #(CLK_P/2) clk = ~clk;

   hist_dir_pred #(.IDX_W(IW), .ADDR_W(AW), .MODE(hdp_pkg::HM_PATH), .PATH_BITS(PB))
   i_hist_dir_pred (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_taken(p_taken), .lk_index(p_index), .lk_ckpt(p_ckpt),
      .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken),
      .up_mispred(up_mispred), .up_ckpt(up_ckpt), .up_addr(up_addr));

   hist_dir_pred #(.IDX_W(IW), .ADDR_W(AW), .MODE(hdp_pkg::HM_OUTCOME), .PATH_BITS(PB))
   i_hist_dir_pred_glb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_taken(g_taken), .lk_index(g_index), .lk_ckpt(g_ckpt),
      .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken),
      .up_mispred(up_mispred), .up_ckpt(up_ckpt), .up_addr(up_addr));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   function automatic logic [IW-1:0] nxt_g(input logic [IW-1:0] h, input logic t);
      return {h[IW-2:0], t};
   endfunction

   function automatic logic [IW-1:0] nxt_p(input logic [IW-1:0] h, input logic t,
                                           input logic [AW-1:0] a);
      logic [3:0] f;
      logic [PB-1:0] b;
      f = a[5:2] ^ a[9:6];
      b = f[PB-1:0];
      b[0] = b[0] ^ t;
      return {h[IW-1-PB:0], b};
   endfunction

   function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
      if (t) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   task automatic drive(input logic lv, input logic [AW-1:0] la, input logic uv,
                        input logic [IW-1:0] ui, input logic ut, input logic um,
                        input logic [IW-1:0] uc, input logic [AW-1:0] ua);
      lk_valid = lv; lk_addr = la; up_valid = uv; up_index = ui;
      up_taken = ut; up_mispred = um; up_ckpt = uc; up_addr = ua;
   endtask

   // check one cycle against the model, then let the edge pass
   task automatic tick(input string tag);
      logic [IW-1:0] ip, ig, nh_p, nh_g;
      logic tp, tg;
      #1;
      ip = mh_p ^ lk_addr[IW+1:2];
      ig = mh_g ^ lk_addr[IW+1:2];
      tp = mc[ip][1];
      tg = mc[ig][1];
      chk({tag, " R4 index path"}, 32'(p_index), 32'(ip));
      chk({tag, " R4 index outcome"}, 32'(g_index), 32'(ig));
      chk({tag, " R3 taken path"}, 32'(p_taken), 32'(tp));
      chk({tag, " R3 taken outcome"}, 32'(g_taken), 32'(tg));
      chk({tag, " history path"}, 32'(p_ckpt), 32'(mh_p));
      chk({tag, " history outcome"}, 32'(g_ckpt), 32'(mh_g));
      if (up_valid && up_mispred) begin
         nh_p = nxt_p(up_ckpt, up_taken, up_addr);
         nh_g = nxt_g(up_ckpt, up_taken);
      end else if (lk_valid) begin
         nh_p = nxt_p(mh_p, tp, lk_addr);
         nh_g = nxt_g(mh_g, tg);
      end else begin
         nh_p = mh_p;
         nh_g = mh_g;
      end
      @(posedge clk);
      if (up_valid) mc[up_index] = sat(mc[up_index], up_taken);
      mh_p = nh_p;
      mh_g = nh_g;
      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0; up_mispred = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 history path after reset", 32'(p_ckpt), 0);
      chk("R1 history outcome after reset", 32'(g_ckpt), 0);
      for (int i = 0; i < 8; i++) begin
         drive(1'b0, 32'(i * 52 + 4), 1'b0, '0, 1'b0, 1'b0, '0, '0);
         #1;
         chk("R1 reset counter predicts not-taken (path)", 32'(p_taken), 0);
         chk("R1 reset counter predicts not-taken (outcome)", 32'(g_taken), 0);
         tick("R1");
      end
   endtask

   task automatic t_train();
      logic [0:7] ut_seq = 8'b1110_0000;
      logic [0:7] exp_t  = 8'b1111_0000;
      logic [AW-1:0] a;
      a = 32'({mh_p ^ 6'd5, 2'b00});
      for (int i = 0; i < 8; i++) begin
         drive(1'b0, a, 1'b1, 6'd5, ut_seq[i], 1'b0, 6'h3f, '0);
         tick("R2");
         chk("R2 saturating counter step", 32'(p_taken), 32'(exp_t[i]));
      end
   endtask

   task automatic t_outcome();
      drive(1'b0, '0, 1'b1, '0, 1'b0, 1'b1, '0, '0);
      tick("R7");
      drive(1'b0, '0, 1'b1, 6'd9, 1'b1, 1'b0, '0, '0);
      tick("R2");
      drive(1'b0, '0, 1'b1, 6'd9, 1'b1, 1'b0, '0, '0);
      tick("R2");
      drive(1'b1, 32'h24, 1'b0, '0, 1'b0, 1'b0, '0, '0);
      tick("R5");
      chk("R5 taken guess enters outcome history", 32'(g_ckpt), 32'h01);
      drive(1'b1, 32'h20, 1'b0, '0, 1'b0, 1'b0, '0, '0);
      tick("R5");
      chk("R5 second taken guess", 32'(g_ckpt), 32'h03);
      drive(1'b1, 32'h00, 1'b0, '0, 1'b0, 1'b0, '0, '0);
      tick("R5");
      chk("R5 not-taken guess", 32'(g_ckpt), 32'h06);
   endtask

   task automatic t_path(input logic [AW-1:0] a, input logic [IW-1:0] exp_p);
      drive(1'b0, '0, 1'b1, 6'd1, 1'b0, 1'b1, '0, '0);
      tick("R7");
      drive(1'b1, a, 1'b0, '0, 1'b0, 1'b0, '0, '0);
      tick("R6");
      chk("R6 path history carries address fold", 32'(p_ckpt), 32'(exp_p));
      chk("R6 outcome history same for both paths", 32'(g_ckpt), 0);
   endtask

   task automatic t_repair();
      drive(1'b1, 32'h100, 1'b1, 6'd0, 1'b1, 1'b1, 6'b101010, 32'h44);
      tick("R7");
      chk("R7 repair overrides lookup (outcome)", 32'(g_ckpt), 32'h15);
      chk("R7 repair overrides lookup (path)", 32'(p_ckpt), 32'h29);
   endtask

   task automatic t_same();
      drive(1'b1, 32'h94, 1'b1, 6'd12, 1'b1, 1'b0, '0, '0);
      #1;
      chk("R9 lookup sees counter before same-cycle update", 32'(p_taken), 0);
      chk("R9 index collides with update", 32'(p_index), 32'd12);
      tick("R9");
      chk("R9 history after colliding lookup", 32'(p_ckpt), 32'h27);
      drive(1'b0, 32'hAC, 1'b0, '0, 1'b0, 1'b0, '0, '0);
      #1;
      chk("R9 update visible next cycle", 32'(p_taken), 1);
      tick("R9");
   endtask

   task automatic t_hold();
      logic [IW-1:0] sp, sg;
      sp = p_ckpt;
      sg = g_ckpt;
      for (int i = 0; i < 3; i++) begin
         drive(1'b0, 32'h40 * i, 1'b1, 6'(i + 20), 1'b1, 1'b0, 6'h2a, 32'h3c);
         tick("R8");
      end
      chk("R8 path history unchanged", 32'(p_ckpt), 32'(sp));
      chk("R8 outcome history unchanged", 32'(g_ckpt), 32'(sg));
   endtask

   initial begin
      #(CLK_P * 100000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      mh_p = '0;
      mh_g = '0;
      for (int i = 0; i < DEPTH; i++) mc[i] = 2'd1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_train();
      t_outcome();
      t_path(32'h44, 6'h00);
      t_path(32'h08, 6'h02);
      t_repair();
      t_same();
      t_hold();
      summary();
      $finish;
   end

endmodule